// File: doc/BRIEF.md
# Peripheral Clock and Reset Gate Controller

This block controls the clock and the reset of a single peripheral. Software drives it over a 32-bit register bus. It has four action registers: one turns the clock on, one turns it off, one asserts the reset and one releases it. Writing a 1 to bit 0 of an action register performs that action. Writing a 0 does nothing.

The gate-enable output and the peripheral reset output follow an accepted action in the next cycle. Two status registers report the clock state and the reset state. Each status bit takes the new state only after the controlled signal has stayed unchanged for a parameterised settle time. Software can therefore poll for completion, just as it would with a real clock or reset tree.

The intended bring-up order is:
1. Assert the reset.
2. Stop the clock.
3. Release the reset.
4. Start the clock.

Top module: `periph_gate_ctrl`

## Requirements
- R1: After power-on reset, `periph_clk_en` is 0 and `periph_rst` is 1. The clock status reads 0 and the reset status reads 1.
- R2: A bus write with `bus_wdata[0]`=1 to offset 0x338 sets `periph_clk_en` to 1 one cycle later. The same write to offset 0x33C sets it to 0 one cycle later.
- R3: A bus write with `bus_wdata[0]`=1 to offset 0xA38 sets `periph_rst` to 1 one cycle later. The same write to offset 0xA3C sets it to 0 one cycle later.
- R4: A write with `bus_wdata[0]`=0, or a write to any other offset, changes neither output nor either status bit.
- R5: Clock status appears in bit 0 at offset 0x531C, and reset status in bit 0 at offset 0x5A1C. All other bits of these two registers read 0.
- R6: A status bit takes the new control value exactly SETTLE clock edges after the write edge that changed it. Until then it keeps its old value.
- R7: If a control value changes again before it has settled, the settle count restarts. A change that is reversed before settling never shows in the status.
- R8: The action registers, and every unmapped offset, read back 0.
- R9: The full sequence (reset assert, clock off, reset release, clock on) leaves `periph_rst`=0 and `periph_clk_en`=1. Once settled, both status bits report that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| periph_clk_en | output | 1 | Gate enable for the peripheral clock |
| periph_rst | output | 1 | Reset to the peripheral, active high |

## Verification
The two outputs are due one edge after the write edge. A status bit is due SETTLE edges after that write edge, and read data is valid in the same cycle as its address. The bench drives inputs on falling edges and samples on the next falling edge, after exactly one rising edge. Its model advances one edge per step. It compares the outputs every step, compares the read data before the edge, and counts idle steps in a directed poll to confirm that the status delay equals SETTLE exactly.

// File: rtl/periph_gate_ctrl.sv
module periph_gate_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int SETTLE    = 4,
  parameter logic [ADDR_W-1:0] A_CLK_ON  = 'h0338,
  parameter logic [ADDR_W-1:0] A_CLK_OFF = 'h033C,
  parameter logic [ADDR_W-1:0] A_RST_ON  = 'h0A38,
  parameter logic [ADDR_W-1:0] A_RST_OFF = 'h0A3C,
  parameter logic [ADDR_W-1:0] A_CLK_ST  = 'h531C,
  parameter logic [ADDR_W-1:0] A_RST_ST  = 'h5A1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              periph_clk_en,
  output logic              periph_rst
);
  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [1:0] CTRL_INIT = 2'b10;

  logic [1:0] ctrl, stat, hit_set, hit_clr, nxt;
  logic [CNT_W-1:0] cnt [2];

  assign hit_set[0] = bus_wr && bus_wdata[0] && bus_addr == A_CLK_ON;
  assign hit_clr[0] = bus_wr && bus_wdata[0] && bus_addr == A_CLK_OFF;
  assign hit_set[1] = bus_wr && bus_wdata[0] && bus_addr == A_RST_ON;
  assign hit_clr[1] = bus_wr && bus_wdata[0] && bus_addr == A_RST_OFF;

  for (genvar i = 0; i < 2; i++) begin : g_ch
    assign nxt[i] = hit_set[i] ? 1'b1 : (hit_clr[i] ? 1'b0 : ctrl[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl[i] <= CTRL_INIT[i];
        stat[i] <= CTRL_INIT[i];
        cnt[i]  <= '0;
      end else begin
        ctrl[i] <= nxt[i];
        if (nxt[i] != ctrl[i]) begin
          cnt[i] <= '0;
        end else if (ctrl[i] != stat[i]) begin
          if (cnt[i] == CNT_W'(SETTLE - 1)) begin
            stat[i] <= ctrl[i];
            cnt[i]  <= '0;
          end else begin
            cnt[i] <= cnt[i] + 1'b1;
          end
        end else begin
          cnt[i] <= '0;
        end
      end
    end

    // R6
    stat_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stat[i]) |-> stat[i] == ctrl[i]);

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[i] < CNT_W'(SETTLE));
  end

  assign periph_clk_en = ctrl[0];
  assign periph_rst    = ctrl[1];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CLK_ST) bus_rdata[0] = stat[0];
    if (bus_addr == A_RST_ST) bus_rdata[0] = stat[1];
  end

  // R2
  clk_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_wdata[0] && bus_addr == A_CLK_ON |=> periph_clk_en);

  // R2
  clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_wdata[0] && bus_addr == A_CLK_OFF |=> !periph_clk_en);

  // R3
  rst_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_wdata[0] && bus_addr == A_RST_ON |=> periph_rst);

  // R3
  rst_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_wdata[0] && bus_addr == A_RST_OFF |=> !periph_rst);

  // R4
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_wdata[0] |=> $stable(periph_clk_en) && $stable(periph_rst));
endmodule

// File: tb/tb_periph_gate_ctrl.sv
module tb_periph_gate_ctrl;
  localparam int SETTLE = 4;
  localparam logic [15:0] A_CON = 16'h0338, A_COFF = 16'h033C,
                          A_RON = 16'h0A38, A_ROFF = 16'h0A3C,
                          A_CST = 16'h531C, A_RST = 16'h5A1C;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic periph_clk_en, periph_rst;
  int tests = 0, fails = 0;

  logic [1:0] m_ctrl, m_stat;
  int m_age [2];

  always #4 clk = ~clk;

  periph_gate_ctrl #(.ADDR_W(16), .SETTLE(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periph_clk_en(periph_clk_en), .periph_rst(periph_rst));

  function automatic logic [31:0] exp_rd(logic [15:0] a);
    if (a == A_CST) return {31'b0, m_stat[0]};
    if (a == A_RST) return {31'b0, m_stat[1]};
    return 32'h0;
  endfunction

  function automatic logic [1:0] exp_ctrl(logic w, logic [15:0] a, logic [31:0] d, logic [1:0] c);
    logic [1:0] n = c;
    if (w && d[0]) begin
      if (a == A_CON)  n[0] = 1'b1;
      if (a == A_COFF) n[0] = 1'b0;
      if (a == A_RON)  n[1] = 1'b1;
      if (a == A_ROFF) n[1] = 1'b0;
    end
    return n;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic w, logic [15:0] a, logic [31:0] d);
    logic [1:0] n;
    bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    check((a == A_CST || a == A_RST) ? "R5 status read" : "R8 read zero", bus_rdata, exp_rd(a));
    n = exp_ctrl(w, a, d, m_ctrl);
    for (int i = 0; i < 2; i++) begin
      if (n[i] != m_ctrl[i]) m_age[i] = 0;
      else if (m_age[i] < SETTLE) m_age[i]++;
      if (m_age[i] >= SETTLE) m_stat[i] = n[i];
    end
    m_ctrl = n;
    @(negedge clk);
    bus_wr = 0;
    check("R2 clk enable out", 32'(periph_clk_en), 32'(m_ctrl[0]));
    check("R3 reset out", 32'(periph_rst), 32'(m_ctrl[1]));
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] addrs [8];
    void'($urandom(32'h5eed));
    addrs = '{A_CON, A_COFF, A_RON, A_ROFF, A_CST, A_RST, 16'h0000, 16'h1234};
    m_ctrl = 2'b10; m_stat = 2'b10; m_age[0] = SETTLE; m_age[1] = SETTLE;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 clk en", 32'(periph_clk_en), 0);
    check("R1 reset", 32'(periph_rst), 1);
    bus_addr = A_CST; #1 check("R1 clk status", bus_rdata, 0);
    bus_addr = A_RST; #1 check("R1 rst status", bus_rdata, 1);
    rst_n = 1;
    @(negedge clk);

    // R9 full sequence, R6 exact latency of each status
    step(1, A_RON, 1);
    step(1, A_COFF, 1);
    step(1, A_ROFF, 1);
    n = 0;
    while (n < 50) begin step(0, A_RST, 0); n++; if (bus_rdata[0] == 0) break; end
    check("R6 reset status latency", n, SETTLE);
    step(1, A_CON, 1);
    n = 0;
    while (n < 50) begin step(0, A_CST, 0); n++; if (bus_rdata[0] == 1) break; end
    check("R6 clock status latency", n, SETTLE);
    check("R9 final clk", 32'(periph_clk_en), 1);
    check("R9 final rst", 32'(periph_rst), 0);

    // R4 zero writes and other offsets
    step(1, A_COFF, 0); step(1, A_RON, 32'hFFFF_FFFE); step(1, 16'h0100, 1);
    check("R4 clk unchanged", 32'(periph_clk_en), 1);
    check("R4 rst unchanged", 32'(periph_rst), 0);
    for (int i = 0; i < SETTLE + 1; i++) step(0, A_CST, 0);
    step(0, A_RST, 0);

    // R7 reversal before settling
    step(1, A_COFF, 1); step(1, A_CON, 1);
    for (int i = 0; i < SETTLE + 2; i++) begin
      step(0, A_CST, 0);
      check("R7 reversed change hidden", m_stat[0], 1);
    end

    // R8 action registers read zero
    step(0, A_CON, 0); step(0, A_COFF, 0); step(0, A_RON, 0); step(0, A_ROFF, 0);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 7);
      step($urandom_range(0, 1) == 1, addrs[r], $urandom_range(0, 3));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule